// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Arbiter

This block chooses which peripheral interrupt an 8-bit microcontroller core services next, and it runs the hardware call sequence that sends the core to the matching vector. It receives nine peripheral request flags with one enable bit per source and a global enable. Each source also carries two priority bits, one high and one low. Together they give a two-bit level, from 0 to 3. The core supplies a strobe once per machine cycle, a marker for the last machine cycle of the current instruction, a marker for instructions that must postpone vectoring, and a pulse for each return-from-interrupt.

Requests are captured on one machine-cycle strobe and polled on the next. The winner is the request with the highest level. Ties within a level are broken by a fixed ranking. The winner is accepted only if its level is strictly above every level already in service. After acceptance the call takes four machine cycles, and then the block raises a one-clock vector pulse. When the call is accepted, the block pulses the hardware clear for the sources that auto-clear. It marks the accepted level as in service. A return clears the highest level in service. A separate combinational output requests wake-up from power-down for the sources that are allowed to wake the device.

Top module: `intc_prio`

## Requirements
- R1: Sources are indexed by ranking. The vectors are: 0 Timer 0 at 16'h000B, 1 I2C at 16'h0033, 2 external interrupt 1 at 16'h0013, 3 keyboard at 16'h003B, 4 comparator 1 at 16'h0063, 5 Timer 1 at 16'h001B, 6 comparator 2 at 16'h0043, 7 serial at 16'h0023, 8 PWM brake at 16'h0073. `call_vec` and `call_src` show the accepted source and stay stable while `call_req` is high.
- R2: The level of source i is {pri_hi[i], pri_lo[i]}. Level 3 is the highest. The pending request with the highest level wins, whatever its index.
- R3: Among pending requests of equal level, the one with the lowest index wins.
- R4: A source is pending only when its flag, its enable and `gie` are all 1 at a machine-cycle strobe. A pending request is polled at the next strobe.
- R5: A request is accepted only at a strobe where `instr_last` is 1 and `instr_defer` is 0. After an instruction that has `instr_defer` set, acceptance can come no earlier than the end of the next instruction.
- R6: When a request is accepted, `call_req` rises. At the fourth strobe after acceptance, `call_req` falls and `vec_go` pulses for one clock. If the flag is captured at strobe k, `vec_go` therefore comes no earlier than strobe k+5.
- R7: `in_svc[L]` is set when a request of level L is accepted. A request is accepted only if its level is strictly above every set bit of `in_svc`.
- R8: A `reti` pulse at a strobe clears the highest set bit of `in_svc`.
- R9: `flag_clr[i]` pulses for one clock after acceptance only for Timer 0, Timer 1, and for external interrupt 1 when `ext1_edge` is 1. The other sources are never cleared by the block.
- R10: `wake` is 1 when `gie` is 1 and at least one of sources 2, 3, 4 or 6 has both its flag and its enable set. No other source raises `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mcyc_stb | input | 1 | One-clock strobe per machine cycle |
| instr_last | input | 1 | Current machine cycle is the last of the instruction |
| instr_defer | input | 1 | Current instruction writes an enable/priority register or is a return |
| reti | input | 1 | Return-from-interrupt, qualified by `mcyc_stb` |
| gie | input | 1 | Global interrupt enable |
| src_flag | input | 9 | Peripheral request flags, indexed by ranking |
| src_en | input | 9 | Per-source enables |
| pri_hi | input | 9 | High priority bit per source |
| pri_lo | input | 9 | Low priority bit per source |
| ext1_edge | input | 1 | External interrupt 1 is edge-triggered |
| call_req | output | 1 | Hardware call in progress |
| call_vec | output | 16 | Vector address of the accepted source |
| call_src | output | 4 | Index of the accepted source |
| vec_go | output | 1 | One-clock pulse: jump to `call_vec` now |
| flag_clr | output | 9 | Hardware flag-clear pulses |
| in_svc | output | 4 | In-service bit per priority level |
| wake | output | 1 | Power-down wake-up request |

## Verification
The assertions assume three things about the inputs. `mcyc_stb` is a single-clock pulse. `reti` has meaning only together with the strobe. Peripherals drop a hardware-cleared flag before the next strobe. The bench enforces all three. Its one machine-cycle task drives every core input for the strobe clock only, and it drops a flag in the clock where the matching clear pulse shows. It also sends a return only after the matching service has begun. Software-cleared flags are dropped by the bench before it issues the return. A source that is still pending therefore shows how the in-service bits block and release requests.

// File: rtl/intc_prio_pkg.sv
package intc_prio_pkg;

   localparam int SRC_COUNT = 9;
   localparam int LVL_W     = 2;
   localparam int LVL_COUNT = 1 << LVL_W;
   localparam int VEC_W     = 16;

   // Index order is the tie-break ranking (0 = strongest)
   localparam int SRC_TMR0 = 0;
   localparam int SRC_EXT1 = 2;
   localparam int SRC_TMR1 = 5;

   function automatic logic [VEC_W-1:0] vec_of(int idx);
      case (idx)
         0:       return 16'h000B;
         1:       return 16'h0033;
         2:       return 16'h0013;
         3:       return 16'h003B;
         4:       return 16'h0063;
         5:       return 16'h001B;
         6:       return 16'h0043;
         7:       return 16'h0023;
         8:       return 16'h0073;
         default: return '0;
      endcase
   endfunction

   function automatic logic hw_clears(int idx, logic edge_mode);
      return (idx == SRC_TMR0) || (idx == SRC_TMR1) ||
             ((idx == SRC_EXT1) && edge_mode);
   endfunction

   function automatic logic can_wake(int idx);
      return (idx == 2) || (idx == 3) || (idx == 4) || (idx == 6);
   endfunction

endpackage

// File: rtl/intc_prio_snap.sv
module intc_prio_snap #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stb,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   input  logic         gie,
   output logic [N-1:0] pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else if (stb)
         pend <= flags & en & {N{gie}};
   end

   // R4: captured set only changes on a strobe
   assert_snap_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stb) |-> $stable(pend));

endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
   parameter int N  = 9,
   parameter int LW = 2,
   parameter int IW = 4
) (
   input  logic [N-1:0]  req,
   input  logic [N-1:0]  hi,
   input  logic [N-1:0]  lo,
   output logic          found,
   output logic [IW-1:0] sel_idx,
   output logic [LW-1:0] sel_lvl
);

   logic [LW-1:0] lvl [N];

   generate
      if (LW != 2) begin : g_bad_lw
         $error("level width must be 2 (high bit, low bit)");
      end
      for (genvar g = 0; g < N; g++) begin : g_lvl
         assign lvl[g] = {hi[g], lo[g]};
      end
   endgenerate

   // Scan from weakest rank upward; >= lets a stronger rank take ties
   always_comb begin
      found   = 1'b0;
      sel_idx = '0;
      sel_lvl = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i] && (!found || lvl[i] >= sel_lvl)) begin
            found   = 1'b1;
            sel_idx = IW'(i);
            sel_lvl = lvl[i];
         end
      end
   end

endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
   parameter int NL = 4,
   parameter int LW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [LW-1:0] set_lvl,
   input  logic          pop,
   output logic [NL-1:0] ins,
   output logic          any,
   output logic [LW-1:0] top
);

   logic [NL-1:0] ins_n;

   generate
      if (NL != (1 << LW)) begin : g_bad_nl
         $error("level count must equal 2**LW");
      end
   endgenerate

   always_comb begin
      top = '0;
      for (int l = 0; l < NL; l++)
         if (ins[l]) top = LW'(l);
   end

   assign any = |ins;

   always_comb begin
      ins_n = ins;
      if (pop && any) ins_n[top] = 1'b0;
      if (set_en)     ins_n[set_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ins <= '0;
      else        ins <= ins_n;
   end

   // R7: a newly accepted level lies above everything already in service
   assert_strict_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> ((ins >> set_lvl) == '0));

   // R8: a lone return removes exactly one level
   assert_pop_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && any && !set_en) |=> ($countones(ins) == $countones($past(ins)) - 1));

endmodule

// File: rtl/intc_prio.sv
module intc_prio
   import intc_prio_pkg::*;
#(
   parameter int N_SRC       = SRC_COUNT,
   parameter int CALL_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mcyc_stb,
   input  logic               instr_last,
   input  logic               instr_defer,
   input  logic               reti,
   input  logic               gie,
   input  logic [8:0]         src_flag,
   input  logic [8:0]         src_en,
   input  logic [8:0]         pri_hi,
   input  logic [8:0]         pri_lo,
   input  logic               ext1_edge,
   output logic               call_req,
   output logic [15:0]        call_vec,
   output logic [3:0]         call_src,
   output logic               vec_go,
   output logic [8:0]         flag_clr,
   output logic [3:0]         in_svc,
   output logic               wake
);

   localparam int IW = 4;
   localparam int CW = (CALL_CYCLES > 1) ? $clog2(CALL_CYCLES) : 1;
   localparam logic [8:0] SW_ONLY  = 9'b1_1101_1010;
   localparam logic [8:0] WAKE_SET = 9'b0_0101_1100;

   generate
      if (N_SRC != SRC_COUNT) begin : g_bad_n
         $error("source table holds exactly SRC_COUNT entries");
      end
      if (CALL_CYCLES < 2) begin : g_bad_call
         $error("call sequence needs at least two machine cycles");
      end
   endgenerate

   logic [N_SRC-1:0] pend, hw_mask, wake_mask;
   logic [VEC_W-1:0] vec_tab [1 << IW];
   logic             found, any_is, accept, busy, go_q;
   logic [IW-1:0]    sel_idx;
   logic [LVL_W-1:0] sel_lvl, top_lvl;
   logic [CW-1:0]    cnt;
   logic [VEC_W-1:0] vec_q;
   logic [IW-1:0]    src_q;
   logic [N_SRC-1:0] clr_q;

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_attr
         assign hw_mask[g]   = hw_clears(g, ext1_edge);
         assign wake_mask[g] = can_wake(g);
      end
      for (genvar v = 0; v < (1 << IW); v++) begin : g_vec
         assign vec_tab[v] = vec_of(v);
      end
   endgenerate

   intc_prio_snap #(.N(N_SRC)) snap_i (
      .clk(clk), .rst_n(rst_n), .stb(mcyc_stb),
      .flags(src_flag), .en(src_en), .gie(gie), .pend(pend)
   );

   intc_prio_arb #(.N(N_SRC), .LW(LVL_W), .IW(IW)) arb_i (
      .req(pend), .hi(pri_hi), .lo(pri_lo),
      .found(found), .sel_idx(sel_idx), .sel_lvl(sel_lvl)
   );

   assign accept = mcyc_stb && instr_last && !instr_defer && !busy && found &&
                   (!any_is || (sel_lvl > top_lvl));

   intc_prio_stack #(.NL(LVL_COUNT), .LW(LVL_W)) stack_i (
      .clk(clk), .rst_n(rst_n), .set_en(accept), .set_lvl(sel_lvl),
      .pop(reti && mcyc_stb), .ins(in_svc), .any(any_is), .top(top_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         go_q  <= 1'b0;
         vec_q <= '0;
         src_q <= '0;
         clr_q <= '0;
      end else begin
         go_q  <= 1'b0;
         clr_q <= '0;
         if (accept) begin
            busy  <= 1'b1;
            cnt   <= '0;
            vec_q <= vec_tab[sel_idx];
            src_q <= sel_idx;
            clr_q <= hw_mask & (N_SRC'(1) << sel_idx);
         end else if (busy && mcyc_stb) begin
            if (cnt == CW'(CALL_CYCLES - 1)) begin
               busy <= 1'b0;
               go_q <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign call_req = busy;
   assign call_vec = vec_q;
   assign call_src = src_q;
   assign vec_go   = go_q;
   assign flag_clr = clr_q;
   assign wake     = gie && |(src_flag & src_en & wake_mask);

   // R9: at most one clear pulse, never for a software-cleared source
   assert_clr_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));
   assert_clr_hw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr & SW_ONLY) == '0);

   // R5: acceptance (seen as a clear pulse) only at a permitted boundary
   assert_accept_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr) |-> $past(mcyc_stb && instr_last && !instr_defer));

   // R6: the jump pulse ends a running call
   assert_go_after_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_go |-> ($past(call_req) && !call_req));

   // R1: vector held while the call runs
   assert_vec_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && $past(call_req)) |-> ($stable(call_vec) && $stable(call_src)));

   // R10: wake only from a wake-capable flag
   assert_wake_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> |(src_flag & WAKE_SET));

endmodule

// File: tb/intc_prio_tb_top.sv
module intc_prio_tb_top;

   logic        clk = 1'b0;
   logic        rst_n, mcyc_stb, instr_last, instr_defer, reti, gie, ext1_edge;
   logic [8:0]  src_flag, src_en, pri_hi, pri_lo;
   logic        call_req, vec_go, wake;
   logic [15:0] call_vec;
   logic [3:0]  call_src, in_svc;
   logic [8:0]  flag_clr;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   bit          go_seen;
   logic [15:0] go_vec;
   logic [3:0]  go_src;
   logic [8:0]  clr_acc;
   int          steps;

   always #5 clk = ~clk;

   intc_prio dut_i (
      .clk(clk), .rst_n(rst_n), .mcyc_stb(mcyc_stb), .instr_last(instr_last),
      .instr_defer(instr_defer), .reti(reti), .gie(gie), .src_flag(src_flag),
      .src_en(src_en), .pri_hi(pri_hi), .pri_lo(pri_lo), .ext1_edge(ext1_edge),
      .call_req(call_req), .call_vec(call_vec), .call_src(call_src),
      .vec_go(vec_go), .flag_clr(flag_clr), .in_svc(in_svc), .wake(wake)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // One machine cycle: strobe clock plus three idle clocks
   task automatic mstep(input bit last, input bit defer, input bit rt);
      @(negedge clk);
      mcyc_stb = 1'b1; instr_last = last; instr_defer = defer; reti = rt;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         if (c == 0) begin
            mcyc_stb = 1'b0; reti = 1'b0; instr_defer = 1'b0;
         end
         if (vec_go) begin
            go_seen = 1'b1; go_vec = call_vec; go_src = call_src;
         end
         clr_acc  = clr_acc | flag_clr;
         src_flag = src_flag & ~flag_clr;
      end
   endtask

   task automatic run_go(input int maxs);
      go_seen = 1'b0; steps = 0;
      while (!go_seen && steps < maxs) begin
         mstep(1'b1, 1'b0, 1'b0);
         steps++;
      end
   endtask

   task automatic do_reti();
      mstep(1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_reset();
      chk(call_req == 1'b0, "R6", "reset call_req", call_req, 0);
      chk(vec_go == 1'b0, "R6", "reset vec_go", vec_go, 0);
      chk(in_svc == 4'h0, "R7", "reset in_svc", in_svc, 0);
      chk(flag_clr == 9'h0, "R9", "reset flag_clr", flag_clr, 0);
   endtask

   task automatic t_latency();
      clr_acc = '0;
      src_flag[0] = 1'b1;
      run_go(20);
      chk(steps == 6, "R6", "Timer0 strobes to jump", steps, 6);
      chk(go_vec == 16'h000B, "R1", "Timer0 vector", go_vec, 16'h000B);
      chk(go_src == 4'd0, "R1", "Timer0 index", go_src, 0);
      chk(clr_acc == 9'h001, "R9", "Timer0 hw clear", clr_acc, 9'h001);
      chk(in_svc == 4'b0001, "R7", "level0 in service", in_svc, 1);
      do_reti();
      chk(in_svc == 4'b0000, "R8", "return clears level0", in_svc, 0);
   endtask

   task automatic t_rank();
      clr_acc = '0;
      src_flag[1] = 1'b1; src_flag[7] = 1'b1; src_flag[8] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h0033, "R3", "I2C wins tie", go_vec, 16'h0033);
      chk(clr_acc == 9'h000, "R9", "I2C not hw cleared", clr_acc, 0);
      src_flag[1] = 1'b0; do_reti();
      run_go(20);
      chk(go_vec == 16'h0023, "R3", "serial before PWM", go_vec, 16'h0023);
      src_flag[7] = 1'b0; do_reti();
      run_go(20);
      chk(go_vec == 16'h0073, "R1", "PWM vector", go_vec, 16'h0073);
      chk(go_src == 4'd8, "R1", "PWM index", go_src, 8);
      src_flag[8] = 1'b0; do_reti();
      chk(in_svc == 4'h0, "R8", "all returned", in_svc, 0);
   endtask

   task automatic t_level();
      pri_hi[8] = 1'b1; pri_lo[8] = 1'b1;
      src_flag[0] = 1'b1; src_flag[8] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h0073, "R2", "level3 PWM beats Timer0", go_vec, 16'h0073);
      chk(in_svc == 4'b1000, "R2", "level3 in service", in_svc, 4'b1000);
      src_flag[8] = 1'b0; do_reti();
      run_go(20);
      chk(go_vec == 16'h000B, "R2", "Timer0 after return", go_vec, 16'h000B);
      do_reti();
      pri_hi = '0; pri_lo = '0;
   endtask

   task automatic t_preempt();
      pri_lo[5] = 1'b1; pri_lo[6] = 1'b1; pri_hi[3] = 1'b1;
      src_flag[5] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h001B, "R1", "Timer1 vector", go_vec, 16'h001B);
      chk(in_svc == 4'b0010, "R7", "level1 in service", in_svc, 4'b0010);
      src_flag[6] = 1'b1;
      run_go(10);
      chk(!go_seen, "R7", "same level does not preempt", go_seen, 0);
      src_flag[3] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h003B, "R7", "higher level preempts", go_vec, 16'h003B);
      chk(in_svc == 4'b0110, "R7", "nested in service", in_svc, 4'b0110);
      src_flag[3] = 1'b0; do_reti();
      chk(in_svc == 4'b0010, "R8", "return pops highest", in_svc, 4'b0010);
      do_reti();
      chk(in_svc == 4'b0000, "R8", "second return", in_svc, 0);
      run_go(20);
      chk(go_vec == 16'h0043, "R1", "comparator2 vector", go_vec, 16'h0043);
      src_flag[6] = 1'b0; do_reti();
      pri_hi = '0; pri_lo = '0;
   endtask

   task automatic t_defer();
      go_seen = 1'b0;
      src_flag[0] = 1'b1;
      mstep(1'b1, 1'b1, 1'b0);
      mstep(1'b1, 1'b1, 1'b0);
      mstep(1'b0, 1'b0, 1'b0);
      chk(call_req == 1'b0, "R5", "deferred and mid-instruction", call_req, 0);
      run_go(20);
      chk(steps == 5, "R5", "accepted at next instruction end", steps, 5);
      chk(go_vec == 16'h000B, "R5", "deferred vector", go_vec, 16'h000B);
      do_reti();
   endtask

   task automatic t_ext1();
      ext1_edge = 1'b1; clr_acc = '0;
      src_flag[2] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h0013, "R1", "ext1 vector", go_vec, 16'h0013);
      chk(clr_acc == 9'h004, "R9", "ext1 edge hw clear", clr_acc, 9'h004);
      do_reti();
      ext1_edge = 1'b0; clr_acc = '0;
      src_flag[2] = 1'b1;
      run_go(20);
      chk(clr_acc == 9'h000, "R9", "ext1 level no clear", clr_acc, 0);
      src_flag[2] = 1'b0; do_reti();
   endtask

   task automatic t_wake();
      @(negedge clk);
      src_flag = 9'h001; #1;
      chk(wake == 1'b0, "R10", "timer cannot wake", wake, 0);
      src_flag = 9'h080; #1;
      chk(wake == 1'b0, "R10", "serial cannot wake", wake, 0);
      src_flag = 9'h040; #1;
      chk(wake == 1'b1, "R10", "comparator2 wakes", wake, 1);
      src_en[3] = 1'b0; src_flag = 9'h008; #1;
      chk(wake == 1'b0, "R10", "disabled keyboard", wake, 0);
      src_en[3] = 1'b1; #1;
      chk(wake == 1'b1, "R10", "enabled keyboard", wake, 1);
      src_flag = '0;
   endtask

   task automatic t_gating();
      gie = 1'b0;
      src_flag[7] = 1'b1;
      run_go(8);
      chk(!go_seen, "R4", "global disable blocks", go_seen, 0);
      gie = 1'b1; src_en[7] = 1'b0;
      run_go(8);
      chk(!go_seen, "R4", "source disable blocks", go_seen, 0);
      src_en[7] = 1'b1;
      run_go(20);
      chk(go_vec == 16'h0023, "R4", "enabled serial taken", go_vec, 16'h0023);
      src_flag[7] = 1'b0; do_reti();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mcyc_stb = 1'b0; instr_last = 1'b1; instr_defer = 1'b0;
      reti = 1'b0; gie = 1'b1; ext1_edge = 1'b1;
      src_flag = '0; src_en = '1; pri_hi = '0; pri_lo = '0;
      clr_acc = '0; go_seen = 1'b0; go_vec = '0; go_src = '0; steps = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_rank();
      t_level();
      t_preempt();
      t_defer();
      t_ext1();
      t_wake();
      t_gating();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule